// File: doc/BRIEF.md
# I2C Channel-Select Register Slave

This block is a serial two-wire slave that owns one 8-bit control register. The register decides which of four downstream channels are connected to the upstream bus. The block runs on a fast system clock and oversamples the SCL and SDA lines. Each line passes through a synchronizer and a glitch filter. The block then detects start and stop conditions, shifts bytes in and out, and acknowledges by pulling SDA low through an open-drain enable. Its output is a 4-bit channel-enable vector, meant to drive external pass gates.

A master programs the channels with a write transfer. The new selection is only staged at first, and it reaches the outputs when the master issues a stop. By that point every downstream line is idle high. A read returns one byte that merges the live state of four active-low interrupt inputs with the channel bits currently applied. An asynchronous active-low reset clears everything to the power-on default, which is no channel selected.

Top module: `chan_sel_slave`

## Requirements
- R1: The slave answers only the 7-bit address whose upper five bits are 1,1,1,0,0 and whose two low bits equal `strap[1:0]` (strap[1] is the higher bit). Bit 0 of the address byte selects the direction: 1 is a read, 0 is a write.
- R2: On a write, bits 3..0 of a data byte select the channels, with bit n enabling channel n. Bits 7..4 are ignored. Any combination is allowed, including none. When several data bytes arrive in one transfer, the last one is kept.
- R3: A written selection changes `chan_en` only in the cycle after a stop condition is detected, and never at any other time.
- R4: A read returns one byte. Bits 7..4 are the inverted `irq_n[3:0]` (1 means that channel has an interrupt pending), sampled when the address acknowledge ends. Bits 3..0 are the applied `chan_en`.
- R5: The slave drives SDA low during the acknowledge clock of a matching address byte and of every data byte written to it.
- R6: While `rst_n` is low, `chan_en` is 0 and `sda_oe` is 0, whatever the bus is doing.
- R7: A start is filtered SDA falling while filtered SCL is high. A stop is filtered SDA rising while filtered SCL is high. A pulse on either line that lasts fewer than `FILT_LEN` clock cycles has no effect.
- R8: After an address that does not match, the slave acknowledges nothing and keeps SDA released until the next start or stop, and `chan_en` is unchanged.
- R9: A repeated start restarts address reception without applying the staged selection. The staged selection is applied at the stop that ends the transfer.
- R10: `sda_oe` changes only while SCL is low.
- R11: During a read, SDA is released after the eighth data bit, so the master's acknowledge bit sees a released line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, also used as power-on reset |
| scl_i | input | 1 | Sampled level of the serial clock line |
| sda_i | input | 1 | Sampled level of the serial data line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap | input | 2 | Low two bits of the slave address |
| irq_n | input | 4 | Active-low interrupt input per channel |
| chan_en | output | 4 | Applied channel enables, bit n for channel n |

## Verification
The bench targets the stop-gated update. It writes a selection and checks that `chan_en` does not move before the stop. It then follows a write with a repeated-start read, which must still report the old channel bits. A design that applied the staged bits early would show the new value in both places. Further tests send several data bytes in one transfer, where a design that kept the first byte or let the upper nibble leak would show the wrong selection. They also send a mismatched address followed by data, which a careless design would acknowledge or latch. Two-cycle spikes on SCL and SDA in the middle of a byte check the filter: without it, the shifted value would be wrong or the transfer would be cut short by a false start or stop.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CH_N    = 4;
  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 2;
  localparam logic [4:0] DEV_PREFIX = 5'b11100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK
  } xfer_st_t;

  // 7-bit address compare: fixed prefix then strap bits, bit 0 is direction
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                    input logic [STRAP_W-1:0] strap);
    return b[BYTE_W-1:1] == {DEV_PREFIX, strap};
  endfunction

  // Read byte: pending interrupts on top, applied channel bits below
  function automatic logic [BYTE_W-1:0] status_byte(input logic [CH_N-1:0] irq_n,
                                                    input logic [CH_N-1:0] ch);
    return {~irq_n, ch};
  endfunction
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic s1, s2;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> ($past(s2) == dout && $past(s2, 2) == dout));
endmodule

// File: rtl/cond_detect.sv
module cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_p  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_p   = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;

  // R7
  cond_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |-> $past(scl_f));
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import chsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_p,
  input  logic               stop_p,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic [STRAP_W-1:0] strap,
  input  logic [CH_N-1:0]    irq_n,
  output logic               sda_oe,
  output logic [CH_N-1:0]    chan_en
);
  localparam int BIT_W = $clog2(BYTE_W);

  xfer_st_t          st;
  logic [BIT_W-1:0]  bit_cnt;
  logic              full;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              is_read;
  logic [CH_N-1:0]   pend;
  logic              pend_v;
  logic              mst_ack;
  logic [CH_N-1:0]   chan_q;
  logic [BYTE_W-1:0] rd_val;
  logic              last_bit;

  assign rd_val   = status_byte(irq_n, chan_q);
  assign last_bit = (bit_cnt == BIT_W'(BYTE_W - 1));
  assign chan_en  = chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      full    <= 1'b0;
      shreg   <= '0;
      tx      <= '0;
      is_read <= 1'b0;
      pend    <= '0;
      pend_v  <= 1'b0;
      mst_ack <= 1'b0;
      chan_q  <= '0;
      sda_oe  <= 1'b0;
    end else if (start_p) begin
      st      <= ST_ADDR;
      bit_cnt <= '0;
      full    <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_p) begin
      st     <= ST_IDLE;
      full   <= 1'b0;
      sda_oe <= 1'b0;
      if (pend_v) begin
        chan_q <= pend;
        pend_v <= 1'b0;
      end
    end else begin
      unique case (st)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            if (st == ST_ADDR) begin
              if (addr_hit(shreg, strap)) begin
                sda_oe  <= 1'b1;
                is_read <= shreg[0];
                st      <= ST_AACK;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              pend   <= shreg[CH_N-1:0];
              pend_v <= 1'b1;
              sda_oe <= 1'b1;
              st     <= ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              tx     <= rd_val;
              sda_oe <= ~rd_val[BYTE_W-1];
              st     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WDAT;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) full <= 1'b1;
          end else if (scl_fall) begin
            if (full) begin
              full   <= 1'b0;
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sda_oe <= ~tx[BYTE_W-2];
              tx     <= {tx[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_f;
          end else if (scl_fall) begin
            if (mst_ack) begin
              bit_cnt <= '0;
              tx      <= rd_val;
              sda_oe  <= ~rd_val[BYTE_W-1];
              st      <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  apply_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_q) |-> $past(stop_p));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(!scl_f) || $past(start_p) || $past(stop_p)));

  // R11
  rack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK) |-> !sda_oe);

  // R5
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK || st == ST_WACK) |-> sda_oe);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/chan_sel_slave.sv
module chan_sel_slave
  import chsel_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic [CH_N-1:0]    irq_n,
  output logic [CH_N-1:0]    chan_en
);
  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] raw_l, filt_l;
  logic start_p, stop_p, scl_rise, scl_fall;

  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_l[g]),
      .dout (filt_l[g])
    );
  end

  cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (filt_l[SCL_IX]),
    .sda_f   (filt_l[SDA_IX]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  xfer_ctrl u_xfer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_p (start_p),
    .stop_p  (stop_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .scl_f   (filt_l[SCL_IX]),
    .sda_f   (filt_l[SDA_IX]),
    .strap   (strap),
    .irq_n   (irq_n),
    .sda_oe  (sda_oe),
    .chan_en (chan_en)
  );

  // R6
  rst_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (chan_en == '0 && !sda_oe));
endmodule

// File: tb/chan_sel_slave_test.sv
module chan_sel_slave_test;
  localparam int Q = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [3:0] irq_n = 4'hF;
  wire        sda_oe;
  wire  [3:0] chan_en;
  wire        sda_line = sda_m & ~sda_oe;

  int  checks = 0;
  int  errors = 0;
  int  oe_viol = 0;
  bit  done = 1'b0;
  logic prev_oe = 1'b0;

  chan_sel_slave uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .strap  (strap),
    .irq_n  (irq_n),
    .chan_en(chan_en)
  );

  // R10 monitor: open-drain enable must not move while the master holds SCL high
  always @(negedge clk) begin
    if (rst_n && scl_m && (sda_oe !== prev_oe)) oe_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b0; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq();
    scl_m = 1'b1; waitq();
    sda_m = 1'b1; waitq();
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_m = b;
    if (glitch) begin
      repeat (8) @(negedge clk); scl_m = 1'b1;
      repeat (2) @(negedge clk); scl_m = 1'b0;
      repeat (Q - 10) @(negedge clk);
    end else waitq();
    scl_m = 1'b1;
    if (glitch) begin
      repeat (8) @(negedge clk); sda_m = ~b;
      repeat (2) @(negedge clk); sda_m = b;
      repeat (Q - 10) @(negedge clk);
    end else waitq();
    waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; waitq();
    scl_m = 1'b1; waitq();
    b = sda_line; waitq();
    scl_m = 1'b0; waitq();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
    get_bit(b);
    acked = (b == 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
  endtask

  function automatic logic [7:0] addr_of(input logic [1:0] a, input logic rd);
    return {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, a[1], a[0], rd};
  endfunction

  // expected read byte: a channel has an interrupt when its input is low
  function automatic logic [7:0] exp_read(input logic [3:0] irqs, input logic [3:0] ch);
    logic [7:0] r;
    for (int i = 0; i < 4; i++) begin
      r[4 + i] = (irqs[i] == 1'b0);
      r[i]     = ch[i];
    end
    return r;
  endfunction

  task automatic t_reset_state();
    chk("R6 chan_en in reset", chan_en, 0);
    chk("R6 sda_oe in reset", sda_oe, 0);
  endtask

  task automatic t_write_basic();
    bit a;
    i2c_start();
    send_byte(addr_of(strap, 1'b0), 1'b0, a);
    chk("R1 R5 address ack", a, 1);
    send_byte(8'h0A, 1'b0, a);
    chk("R5 data ack", a, 1);
    chk("R3 chan_en unchanged before stop", chan_en, 0);
    i2c_stop();
    chk("R3 R2 chan_en after stop", chan_en, 4'hA);
  endtask

  task automatic t_read_status();
    bit a;
    logic [7:0] v;
    logic nack_line;
    irq_n = 4'b1010;
    i2c_start();
    send_byte(addr_of(strap, 1'b1), 1'b0, a);
    chk("R1 read address ack", a, 1);
    recv_byte(v);
    chk("R4 read byte", v, exp_read(4'b1010, 4'hA));
    get_bit(nack_line);
    chk("R11 line released at master ack", nack_line, 1);
    i2c_stop();
    chk("R4 read leaves chan_en", chan_en, 4'hA);
    irq_n = 4'hF;
  endtask

  task automatic t_multi_byte();
    bit a;
    i2c_start();
    send_byte(addr_of(strap, 1'b0), 1'b0, a);
    send_byte(8'hF3, 1'b0, a);
    chk("R5 first data ack", a, 1);
    send_byte(8'h06, 1'b0, a);
    chk("R5 second data ack", a, 1);
    i2c_stop();
    chk("R2 last byte kept, upper bits ignored", chan_en, 4'h6);
  endtask

  task automatic t_miss();
    bit a;
    i2c_start();
    send_byte(addr_of(2'b01, 1'b0), 1'b0, a);
    chk("R1 R8 foreign address not acked", a, 0);
    send_byte(8'h0F, 1'b0, a);
    chk("R8 data after miss not acked", a, 0);
    i2c_stop();
    chk("R8 chan_en unchanged after miss", chan_en, 4'h6);
  endtask

  task automatic t_rep_start();
    bit a;
    logic [7:0] v;
    logic nb;
    i2c_start();
    send_byte(addr_of(strap, 1'b0), 1'b0, a);
    send_byte(8'h09, 1'b0, a);
    chk("R9 staged write ack", a, 1);
    i2c_start();
    send_byte(addr_of(strap, 1'b1), 1'b0, a);
    chk("R9 address ack after repeated start", a, 1);
    recv_byte(v);
    chk("R9 read shows old channel bits", v, exp_read(4'hF, 4'h6));
    chk("R9 chan_en held across repeated start", chan_en, 4'h6);
    get_bit(nb);
    i2c_stop();
    chk("R9 staged bits applied at stop", chan_en, 4'h9);
  endtask

  task automatic t_glitch();
    bit a;
    i2c_start();
    send_byte(addr_of(strap, 1'b0), 1'b0, a);
    send_byte(8'h03, 1'b1, a);
    chk("R7 ack despite short spikes", a, 1);
    i2c_stop();
    chk("R7 spikes rejected", chan_en, 4'h3);
  endtask

  task automatic t_none_and_strap();
    bit a;
    strap = 2'b11;
    repeat (4) @(negedge clk);
    i2c_start();
    send_byte(addr_of(2'b11, 1'b0), 1'b0, a);
    chk("R1 other strap value acked", a, 1);
    send_byte(8'hF0, 1'b0, a);
    i2c_stop();
    chk("R2 no channel selected", chan_en, 0);
    strap = 2'b10;
  endtask

  task automatic t_async_reset();
    bit a;
    i2c_start();
    send_byte(addr_of(strap, 1'b0), 1'b0, a);
    send_byte(8'h05, 1'b0, a);
    i2c_stop();
    chk("R2 pre-reset selection", chan_en, 4'h5);
    i2c_start();
    put_bit(1'b1, 1'b0);
    #3 rst_n = 1'b0;
    #1 chk("R6 async clear", chan_en, 0);
    repeat (3) @(negedge clk);
    chk("R6 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    i2c_stop();
    chk("R6 stays clear after reset", chan_en, 0);
    i2c_start();
    send_byte(addr_of(strap, 1'b0), 1'b0, a);
    chk("R6 usable after reset", a, 1);
    send_byte(8'h0C, 1'b0, a);
    i2c_stop();
    chk("R3 write after reset applied", chan_en, 4'hC);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_write_basic();
    t_read_status();
    t_multi_byte();
    t_miss();
    t_rep_start();
    t_glitch();
    t_none_and_strap();
    t_async_reset();
    chk("R10 sda_oe stable while SCL high", oe_viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule